// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. A word is stored on a write-clock rising edge only when both write enables are high and the buffer is not full. A word is taken on a read-clock rising edge only when both read enables are high and the buffer is not empty. Depth and word width are parameters. The nominal size is 1024 words of 36 bits, and the depth must be a power of two.

Five registered level flags report the fill state: full, almost-full and half-full on the write clock, and empty and almost-empty on the read clock. The two pointers cross between the clock domains in Gray code through two-flop synchronisers. The almost-full and almost-empty distances are held in a small threshold store. Either side can reprogram that store through its own load strobe. A value meant for the other clock domain is carried across by a toggle handshake. Reset restores a distance of eight locations for both thresholds.

Top module: `afifo_dual_clk`

## Requirements
- R1: A word is stored on a write-clock edge only when `wr_en_a` and `wr_en_b` are both 1. With either enable low, the fill level and the read-side flags stay unchanged. The write pointer moves by at most one location per write-clock cycle.
- R2: A word is removed only when `rd_en_a` and `rd_en_b` are both 1. `rd_data` shows the oldest stored word from the read-clock edge that removes it until the next removal. With either enable low, `rd_data` holds its value.
- R3: A write attempted while `full` is 1 is dropped. It does not advance the write pointer and does not alter any stored word.
- R4: A read attempted while `empty` is 1 is dropped. It does not advance the read pointer and does not change `rd_data`.
- R5: `full` is a write-clock register. It is 1 exactly when the stored word count equals DEPTH.
- R6: After a synchronous reset (active-high `wr_rst`/`rd_rst`), `full`, `almost_full` and `half_full` are 0. `empty` and `almost_empty` are 1, and `rd_data` is 0.
- R7: `half_full` is a write-clock register. It is 1 when the count is at least DEPTH/2.
- R8: `almost_full` is a write-clock register. It is 1 when count + AF distance >= DEPTH. The AF distance is 8 after reset.
- R9: `almost_empty` is a read-clock register. It is 1 when count <= AE distance. The AE distance is 8 after reset. `empty` is 1 exactly when the count is 0.
- R10: A write-side strobe `wr_thr_load` loads `wr_thr_val` into the threshold selected by `wr_thr_sel`. The encoding is 1 for the AF distance and 0 for the AE distance. An AE value crosses to the read clock before it takes effect.
- R11: A read-side strobe `rd_thr_load` loads `rd_thr_val` using the same encoding. An AF value crosses to the write clock. If a local load and a crossed load reach the same register in the same cycle, the local load wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | WIDTH | Word to store |
| wr_thr_load | input | 1 | Threshold load strobe, write side |
| wr_thr_sel | input | 1 | Threshold select: 1 = AF distance, 0 = AE distance |
| wr_thr_val | input | log2(DEPTH)+1 | Threshold distance, 0..DEPTH |
| full | output | 1 | Buffer full |
| almost_full | output | 1 | Count within AF distance of full |
| half_full | output | 1 | Count at least DEPTH/2 |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| rd_data | output | WIDTH | Most recently removed word |
| rd_thr_load | input | 1 | Threshold load strobe, read side |
| rd_thr_sel | input | 1 | Threshold select: 1 = AF distance, 0 = AE distance |
| rd_thr_val | input | log2(DEPTH)+1 | Threshold distance, 0..DEPTH |
| empty | output | 1 | Buffer empty |
| almost_empty | output | 1 | Count within AE distance of empty |

## Verification
The assertions rely on three conditions at the inputs:
- Both resets are held together for several cycles of each clock.
- Threshold values never exceed DEPTH.
- Two loads that must cross to the same far domain are spaced by at least four cycles of the far clock, because the crossing register is sampled a few far-clock edges after its toggle.

The stimulus runs the two clocks at different periods and issues every threshold load as a single-cycle strobe. After each burst and each load it waits several cycles of both clocks. Every value checked is therefore taken from a settled state in which both synchronised pointers have caught up.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;

    localparam int DEF_OFFSET = 8;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } thr_sel_e;

    typedef struct packed {
        logic full;
        logic afull;
        logic hfull;
    } wflags_t;

    typedef struct packed {
        logic empty;
        logic aempty;
    } rflags_t;

    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/afifo_cfg_xfer.sv
`timescale 1ns/1ps
module afifo_cfg_xfer #(
    parameter int W = 8
) (
    input  logic         src_clk,
    input  logic         src_rst,
    input  logic         src_load,
    input  logic [W-1:0] src_val,
    input  logic         dst_clk,
    input  logic         dst_rst,
    output logic         dst_load,
    output logic [W-1:0] dst_val
);
    logic         tog_q;
    logic [W-1:0] hold_q;
    logic         tog_s;
    logic         tog_d;

    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            tog_q  <= 1'b0;
            hold_q <= '0;
        end else if (src_load) begin
            tog_q  <= ~tog_q;
            hold_q <= src_val;
        end
    end

    afifo_sync #(.W(1)) u_tog_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (tog_q),
        .q   (tog_s)
    );

    always_ff @(posedge dst_clk) begin
        if (dst_rst) tog_d <= 1'b0;
        else         tog_d <= tog_s;
    end

    assign dst_load = tog_s ^ tog_d;
    assign dst_val  = hold_q;
endmodule

// File: rtl/afifo_wr_side.sv
`timescale 1ns/1ps
module afifo_wr_side
    import afifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1,
    input  logic          en2,
    input  logic [AW:0]   rgray_s,
    input  logic          ld_local,
    input  logic [AW:0]   val_local,
    input  logic          ld_remote,
    input  logic [AW:0]   val_remote,
    output logic [AW:0]   wbin_q,
    output logic [AW:0]   wgray_q,
    output logic          we,
    output wflags_t       flags_q
);
    localparam int PW = AW + 1;
    localparam int EW = AW + 2;

    logic [AW:0] wbin_nx;
    logic [AW:0] rbin_s;
    logic [AW:0] cnt_nx;
    logic [AW:0] af_off_q;

    assign rbin_s  = PW'(from_gray(32'(rgray_s)));
    assign we      = en1 & en2 & ~flags_q.full;
    assign wbin_nx = wbin_q + {{AW{1'b0}}, we};
    assign cnt_nx  = wbin_nx - rbin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            flags_q <= '0;
        end else begin
            wbin_q        <= wbin_nx;
            wgray_q       <= PW'(to_gray(32'(wbin_nx)));
            flags_q.full  <= (cnt_nx == PW'(DEPTH));
            flags_q.hfull <= (cnt_nx >= PW'(DEPTH / 2));
            flags_q.afull <= (({1'b0, cnt_nx} + {1'b0, af_off_q}) >= EW'(DEPTH));
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            af_off_q <= PW'(DEF_OFFSET);
        else if (ld_local)  af_off_q <= val_local;
        else if (ld_remote) af_off_q <= val_remote;
    end

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (wbin_q == $past(wbin_q)) || (wbin_q == $past(wbin_q) + PW'(1))); // R1
    AST_WGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(wgray_q ^ $past(wgray_q)) <= 1); // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (flags_q.full && en1 && en2) |=> $stable(wbin_q)); // R3
    AST_FULL_HALF: assert property (@(posedge clk) disable iff (rst)
        flags_q.full |-> flags_q.hfull); // R7
    AST_FULL_ALMOST: assert property (@(posedge clk) disable iff (rst)
        flags_q.full |-> flags_q.afull); // R8
endmodule

// File: rtl/afifo_rd_side.sv
`timescale 1ns/1ps
module afifo_rd_side
    import afifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en1,
    input  logic          en2,
    input  logic [AW:0]   wgray_s,
    input  logic          ld_local,
    input  logic [AW:0]   val_local,
    input  logic          ld_remote,
    input  logic [AW:0]   val_remote,
    output logic [AW:0]   rbin_q,
    output logic [AW:0]   rgray_q,
    output logic          re,
    output rflags_t       flags_q
);
    localparam int PW = AW + 1;

    logic [AW:0] rbin_nx;
    logic [AW:0] wbin_s;
    logic [AW:0] cnt_nx;
    logic [AW:0] ae_off_q;

    assign wbin_s  = PW'(from_gray(32'(wgray_s)));
    assign re      = en1 & en2 & ~flags_q.empty;
    assign rbin_nx = rbin_q + {{AW{1'b0}}, re};
    assign cnt_nx  = wbin_s - rbin_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            flags_q <= '{empty: 1'b1, aempty: 1'b1};
        end else begin
            rbin_q         <= rbin_nx;
            rgray_q        <= PW'(to_gray(32'(rbin_nx)));
            flags_q.empty  <= (cnt_nx == '0);
            flags_q.aempty <= (cnt_nx <= ae_off_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ae_off_q <= PW'(DEF_OFFSET);
        else if (ld_local)  ae_off_q <= val_local;
        else if (ld_remote) ae_off_q <= val_remote;
    end

    AST_RPTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rbin_q == $past(rbin_q)) || (rbin_q == $past(rbin_q) + PW'(1))); // R2
    AST_RGRAY_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        $countones(rgray_q ^ $past(rgray_q)) <= 1); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (flags_q.empty && en1 && en2) |=> $stable(rbin_q)); // R4
    AST_EMPTY_ALMOST: assert property (@(posedge clk) disable iff (rst)
        flags_q.empty |-> flags_q.aempty); // R9
endmodule

// File: rtl/afifo_dual_clk.sv
`timescale 1ns/1ps
module afifo_dual_clk
    import afifo_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int DEPTH = 1024
) (
    input  logic                     wr_clk,
    input  logic                     wr_rst,
    input  logic                     wr_en_a,
    input  logic                     wr_en_b,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic                     wr_thr_load,
    input  logic                     wr_thr_sel,
    input  logic [$clog2(DEPTH):0]   wr_thr_val,
    output logic                     full,
    output logic                     almost_full,
    output logic                     half_full,
    input  logic                     rd_clk,
    input  logic                     rd_rst,
    input  logic                     rd_en_a,
    input  logic                     rd_en_b,
    output logic [WIDTH-1:0]         rd_data,
    input  logic                     rd_thr_load,
    input  logic                     rd_thr_sel,
    input  logic [$clog2(DEPTH):0]   rd_thr_val,
    output logic                     empty,
    output logic                     almost_empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];

    logic [AW:0] wbin, wgray, wgray_s;
    logic [AW:0] rbin, rgray, rgray_s;
    logic        we, re;
    wflags_t     wflags;
    rflags_t     rflags;

    thr_sel_e    wsel, rsel;
    logic        wr_af_local, wr_ae_far;
    logic        rd_ae_local, rd_af_far;
    logic        af_far_ld, ae_far_ld;
    logic [AW:0] af_far_val, ae_far_val;

    assign wsel        = thr_sel_e'(wr_thr_sel);
    assign rsel        = thr_sel_e'(rd_thr_sel);
    assign wr_af_local = wr_thr_load && (wsel == SEL_AF);
    assign wr_ae_far   = wr_thr_load && (wsel == SEL_AE);
    assign rd_ae_local = rd_thr_load && (rsel == SEL_AE);
    assign rd_af_far   = rd_thr_load && (rsel == SEL_AF);

    afifo_sync #(.W(AW + 1)) u_rptr_to_w (
        .clk (wr_clk), .rst (wr_rst), .d (rgray), .q (rgray_s)
    );

    afifo_sync #(.W(AW + 1)) u_wptr_to_r (
        .clk (rd_clk), .rst (rd_rst), .d (wgray), .q (wgray_s)
    );

    afifo_cfg_xfer #(.W(AW + 1)) u_ae_xfer (
        .src_clk (wr_clk), .src_rst (wr_rst),
        .src_load (wr_ae_far), .src_val (wr_thr_val),
        .dst_clk (rd_clk), .dst_rst (rd_rst),
        .dst_load (ae_far_ld), .dst_val (ae_far_val)
    );

    afifo_cfg_xfer #(.W(AW + 1)) u_af_xfer (
        .src_clk (rd_clk), .src_rst (rd_rst),
        .src_load (rd_af_far), .src_val (rd_thr_val),
        .dst_clk (wr_clk), .dst_rst (wr_rst),
        .dst_load (af_far_ld), .dst_val (af_far_val)
    );

    afifo_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk (wr_clk), .rst (wr_rst),
        .en1 (wr_en_a), .en2 (wr_en_b),
        .rgray_s (rgray_s),
        .ld_local (wr_af_local), .val_local (wr_thr_val),
        .ld_remote (af_far_ld), .val_remote (af_far_val),
        .wbin_q (wbin), .wgray_q (wgray), .we (we), .flags_q (wflags)
    );

    afifo_rd_side #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk (rd_clk), .rst (rd_rst),
        .en1 (rd_en_a), .en2 (rd_en_b),
        .wgray_s (wgray_s),
        .ld_local (rd_ae_local), .val_local (rd_thr_val),
        .ld_remote (ae_far_ld), .val_remote (ae_far_val),
        .rbin_q (rbin), .rgray_q (rgray), .re (re), .flags_q (rflags)
    );

    always_ff @(posedge wr_clk) begin
        if (we) mem[wbin[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge rd_clk) begin
        if (rd_rst)  rd_data <= '0;
        else if (re) rd_data <= mem[rbin[AW-1:0]];
    end

    assign full         = wflags.full;
    assign almost_full  = wflags.afull;
    assign half_full    = wflags.hfull;
    assign empty        = rflags.empty;
    assign almost_empty = rflags.aempty;

    AST_RDATA_HOLD: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (empty && rd_en_a && rd_en_b) |=> $stable(rd_data)); // R4
endmodule

// File: tb/afifo_dual_clk_tb_top.sv
`timescale 1ns/1ps
module afifo_dual_clk_tb_top;
    localparam int W  = 36;
    localparam int D  = 32;
    localparam int PW = $clog2(D) + 1;

    typedef struct packed {
        logic [7:0] nw;
        logic [7:0] nr;
        logic [4:0] flg;
    } vec_t;

    // flg = {full, almost_full, half_full, almost_empty, empty}
    localparam vec_t VEC [17] = '{
        '{8'd4, 8'd0, 5'b00010},
        '{8'd4, 8'd0, 5'b00010},
        '{8'd1, 8'd0, 5'b00000},
        '{8'd7, 8'd0, 5'b00100},
        '{8'd7, 8'd0, 5'b00100},
        '{8'd1, 8'd0, 5'b01100},
        '{8'd7, 8'd0, 5'b01100},
        '{8'd1, 8'd0, 5'b11100},
        '{8'd3, 8'd0, 5'b11100},
        '{8'd0, 8'd1, 5'b01100},
        '{8'd0, 8'd8, 5'b00100},
        '{8'd0, 8'd8, 5'b00000},
        '{8'd0, 8'd7, 5'b00010},
        '{8'd0, 8'd8, 5'b00011},
        '{8'd0, 8'd2, 5'b00011},
        '{8'd1, 8'd0, 5'b00010},
        '{8'd0, 8'd1, 5'b00011}
    };

    logic          wr_clk = 1'b0, rd_clk = 1'b0;
    logic          wr_rst = 1'b1, rd_rst = 1'b1;
    logic          wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          wr_thr_load = 1'b0, wr_thr_sel = 1'b0;
    logic [PW-1:0] wr_thr_val = '0;
    logic          rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic          rd_thr_load = 1'b0, rd_thr_sel = 1'b0;
    logic [PW-1:0] rd_thr_val = '0;
    logic          full, almost_full, half_full, empty, almost_empty;
    logic [W-1:0]  rd_data;

    int            n_chk = 0, n_fail = 0;
    int            seq = 0, m_cnt = 0, m_wr = 0, m_rd = 0;
    logic [W-1:0]  m_q [64];
    logic [W-1:0]  last_rd = '0;

    always #2.5 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    afifo_dual_clk #(.WIDTH(W), .DEPTH(D)) dut_i (
        .wr_clk (wr_clk), .wr_rst (wr_rst), .wr_en_a (wr_en_a), .wr_en_b (wr_en_b),
        .wr_data (wr_data), .wr_thr_load (wr_thr_load), .wr_thr_sel (wr_thr_sel),
        .wr_thr_val (wr_thr_val), .full (full), .almost_full (almost_full),
        .half_full (half_full), .rd_clk (rd_clk), .rd_rst (rd_rst),
        .rd_en_a (rd_en_a), .rd_en_b (rd_en_b), .rd_data (rd_data),
        .rd_thr_load (rd_thr_load), .rd_thr_sel (rd_thr_sel), .rd_thr_val (rd_thr_val),
        .empty (empty), .almost_empty (almost_empty)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic wr_word(input logic e1, input logic e2);
        @(negedge wr_clk);
        seq++;
        wr_data = 36'h9_0000_0000 | W'(seq);
        wr_en_a = e1;
        wr_en_b = e2;
        if (e1 && e2 && m_cnt < D) begin
            m_q[m_wr % 64] = wr_data;
            m_wr++;
            m_cnt++;
        end
        @(negedge wr_clk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
    endtask

    task automatic rd_word(input logic e1, input logic e2);
        logic [W-1:0] exp;
        exp = last_rd;
        @(negedge rd_clk);
        rd_en_a = e1;
        rd_en_b = e2;
        if (e1 && e2 && m_cnt > 0) begin
            exp = m_q[m_rd % 64];
            m_rd++;
            m_cnt--;
        end
        @(negedge rd_clk);
        rd_en_a = 1'b0;
        rd_en_b = 1'b0;
        chk("R2/R3/R4 read data", 64'(rd_data), 64'(exp));
        last_rd = exp;
    endtask

    task automatic cfg_w(input logic sel, input logic [PW-1:0] val);
        @(negedge wr_clk);
        wr_thr_load = 1'b1; wr_thr_sel = sel; wr_thr_val = val;
        @(negedge wr_clk);
        wr_thr_load = 1'b0;
        settle();
    endtask

    task automatic cfg_r(input logic sel, input logic [PW-1:0] val);
        @(negedge rd_clk);
        rd_thr_load = 1'b1; rd_thr_sel = sel; rd_thr_val = val;
        @(negedge rd_clk);
        rd_thr_load = 1'b0;
        settle();
    endtask

    function automatic logic [4:0] flags();
        return {full, almost_full, half_full, almost_empty, empty};
    endfunction

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (6) @(negedge rd_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        settle();
        // R6: reset state
        chk("R6 reset flags", 64'(flags()), 64'(5'b00011));
        chk("R6 reset rd_data", 64'(rd_data), 64'h0);

        // R1: a single write enable stores nothing
        wr_word(1'b1, 1'b0);
        wr_word(1'b0, 1'b1);
        settle();
        chk("R1 one write enable ignored", 64'(flags()), 64'(5'b00011));

        // R2: a single read enable removes nothing
        wr_word(1'b1, 1'b1);
        settle();
        rd_word(1'b1, 1'b0);
        rd_word(1'b0, 1'b1);
        chk("R2 one read enable, still not empty", 64'(empty), 64'h0);
        rd_word(1'b1, 1'b1);
        settle();
        chk("R2/R9 drained", 64'(flags()), 64'(5'b00011));

        // table: R3 R4 R5 R7 R8 R9
        for (int v = 0; v < 17; v++) begin
            for (int k = 0; k < int'(VEC[v].nw); k++) wr_word(1'b1, 1'b1);
            for (int k = 0; k < int'(VEC[v].nr); k++) rd_word(1'b1, 1'b1);
            settle();
            chk($sformatf("R3/R4/R5/R7/R8/R9 flags vec %0d", v),
                64'(flags()), 64'(VEC[v].flg));
        end

        // R10: write-side loads (sel 0 = AE crosses, 1 = AF local)
        cfg_w(1'b0, PW'(2));
        repeat (3) wr_word(1'b1, 1'b1);
        settle();
        chk("R10 AE=2 from write side, count 3", 64'(almost_empty), 64'h0);
        cfg_w(1'b1, PW'(30));
        chk("R10 AF=30 from write side, count 3", 64'(almost_full), 64'h1);

        // R11: read-side loads (sel 1 = AF crosses, 0 = AE local)
        cfg_r(1'b1, PW'(4));
        chk("R11 AF=4 from read side, count 3", 64'(almost_full), 64'h0);
        cfg_r(1'b0, PW'(3));
        chk("R11 AE=3 from read side, count 3", 64'(almost_empty), 64'h1);
        cfg_w(1'b1, PW'(0));
        chk("R8 AF=0 tracks full, count 3", 64'(almost_full), 64'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule